// File: doc/BRIEF.md
# Blit Register File and Launch Control

This block is the byte-wide register front end of a 2D blit engine. Software writes bytes at register offsets to set the destination and source addresses, the operation mode, the extended mode, the raster-operation code, the transparency key colour and a control byte. The drawing datapath is a separate block that reads these fields from the outputs.

The block also decides when a blit launches. A launch comes from a control-byte write with the go bit set. On the newer chip revision, when the auto-start bit is already held in the control byte, a write to the top destination byte also launches a blit. If the mode selects the host (system memory) source, the launch does not pulse the engine. It arms a host-to-screen transfer instead: it pulses a clear for the host byte, buffer, pixel and scan counters, and it takes snapshots of both addresses.

A revision input decides which registers can be written. A width input decides whether the destination address keeps 22 or 21 bits. A busy flag blocks any further launch until the engine reports that it is done.

Top module: `blt_ctl_top`

## Requirements
- R1: After reset, every register output, the snapshots, `busy`, `host_arm`, `start_pulse` and `cnt_clr` are all zero.
- R2: Byte writes load the fields at these offsets. Destination bytes go to 0x10, 0x11 and 0x12, and source bytes to 0x14, 0x15 and 0x16, both least significant byte first. The mode is at 0x18, the ROP code at 0x1a, the key colour high byte at 0x1d and the control byte at 0x40.
- R3: A destination write is masked to 22 bits when `wide_addr`=1 and to 21 bits (bit 21 cleared) when `wide_addr`=0. The source is kept to 22 bits.
- R4: The extended-mode byte at 0x1b takes writes only when `rev_new`=1. When `rev_new`=0, the write is ignored.
- R5: The key colour low byte at 0x1c takes writes only when `rev_new`=0. When `rev_new`=1, the write is ignored.
- R6: A write to 0x40 with bit 1 set launches a blit. For a non-host mode, `start_pulse` is high in the cycle after the write edge and `busy` is set. A write to 0x40 with bit 1 clear does not launch.
- R7: When `rev_new`=1 and bit 7 of the stored control byte is set, a write to 0x12 launches a blit. This write does not launch when `rev_new`=0 or when bit 7 is clear.
- R8: A launch with mode = 0x04 (host source) gives no `start_pulse`. It sets `host_arm`, pulses `cnt_clr`, and latches the destination and source addresses into `dst_snap` and `src_snap`.
- R9: `eng_done` clears `busy` and `host_arm`. A launch requested while `busy` is high is ignored.
- R10: `start_pulse` and `cnt_clr` each last exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_new | input | 1 | 1 selects the newer chip revision |
| wide_addr | input | 1 | 1 gives a 22-bit destination, 0 gives 21 bits |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Register offset |
| wr_data | input | 8 | Write data |
| eng_done | input | 1 | Engine finished the current blit |
| dst_addr | output | 22 | Destination address |
| src_addr | output | 22 | Source address |
| mode | output | 8 | Operation mode |
| mode_ext | output | 8 | Extended mode |
| rop | output | 8 | Raster-operation code |
| key_col | output | 16 | Transparency key colour |
| ctl | output | 8 | Control byte |
| busy | output | 1 | Blit in progress |
| start_pulse | output | 1 | One-cycle engine start |
| host_arm | output | 1 | Host data transfer armed |
| cnt_clr | output | 1 | One-cycle clear of the host and pixel counters |
| dst_snap | output | 22 | Destination address latched at a host launch |
| src_snap | output | 22 | Source address latched at a host launch |

## Verification
Launches are tried from three triggers. The first is a control write with the go bit, which is compared with a control write without it. The second is an auto-start destination write, tried with the revision flag and the auto bit in each combination. The third is a repeat request while busy. Each trigger is run with an ordinary mode and with the host-source mode, so an immediate start can be told apart from an armed transfer. The destination top byte is written with all ones in both width settings, which shows which mask applies. The same register writes are made under each revision, which shows which offsets are gated.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam logic [7:0] OFS_DST  = 8'h10;
  localparam logic [7:0] OFS_SRC  = 8'h14;
  localparam logic [7:0] OFS_MODE = 8'h18;
  localparam logic [7:0] OFS_ROP  = 8'h1a;
  localparam logic [7:0] OFS_MEXT = 8'h1b;
  localparam logic [7:0] OFS_KEYL = 8'h1c;
  localparam logic [7:0] OFS_KEYH = 8'h1d;
  localparam logic [7:0] OFS_CTL  = 8'h40;
  localparam int CTL_GO_BIT   = 1;
  localparam int CTL_AUTO_BIT = 7;
  localparam logic [7:0] HOST_SRC_MODE = 8'h04;
endpackage

// File: rtl/blt_regfile.sv
module blt_regfile
  import blt_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rev_new,
  input  logic          wide_addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] dst_nxt,
  output logic [AW-1:0] src_q,
  output logic [7:0]    mode_q,
  output logic [7:0]    mext_q,
  output logic [7:0]    rop_q,
  output logic [15:0]   key_q,
  output logic [7:0]    ctl_q
);
  localparam int NB = (AW + 7) / 8;

  logic [NB-1:0] dst_lane, src_lane;
  logic          dst_we, src_we;
  logic [AW-1:0] src_nxt, lim;
  logic          mode_we, rop_we, mext_we, keyl_we, keyh_we, ctl_we;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      dst_lane[b] = wr_en && (wr_addr == 8'(OFS_DST + b));
      src_lane[b] = wr_en && (wr_addr == 8'(OFS_SRC + b));
    end
    dst_we = |dst_lane;
    src_we = |src_lane;
    lim    = wide_addr ? '1 : {1'b0, {(AW-1){1'b1}}};
    dst_nxt = dst_q;
    src_nxt = src_q;
    for (int i = 0; i < AW; i++) begin
      if (dst_lane[i/8]) dst_nxt[i] = wr_data[i%8];
      if (src_lane[i/8]) src_nxt[i] = wr_data[i%8];
    end
    dst_nxt = dst_nxt & lim;
    mode_we = wr_en && (wr_addr == OFS_MODE);
    rop_we  = wr_en && (wr_addr == OFS_ROP);
    mext_we = wr_en && (wr_addr == OFS_MEXT) && rev_new;
    keyl_we = wr_en && (wr_addr == OFS_KEYL) && !rev_new;
    keyh_we = wr_en && (wr_addr == OFS_KEYH);
    ctl_we  = wr_en && (wr_addr == OFS_CTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      src_q  <= '0;
      mode_q <= '0;
      mext_q <= '0;
      rop_q  <= '0;
      key_q  <= '0;
      ctl_q  <= '0;
    end else begin
      if (dst_we)  dst_q        <= dst_nxt;
      if (src_we)  src_q        <= src_nxt;
      if (mode_we) mode_q       <= wr_data;
      if (mext_we) mext_q       <= wr_data;
      if (rop_we)  rop_q        <= wr_data;
      if (keyl_we) key_q[7:0]   <= wr_data;
      if (keyh_we) key_q[15:8]  <= wr_data;
      if (ctl_we)  ctl_q        <= wr_data;
    end
  end
endmodule

// File: rtl/blt_launch.sv
module blt_launch
  import blt_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rev_new,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [7:0]    ctl_q,
  input  logic [7:0]    mode_q,
  input  logic [AW-1:0] dst_nxt,
  input  logic [AW-1:0] src_q,
  input  logic          eng_done,
  output logic          busy_q,
  output logic          pulse_q,
  output logic          arm_q,
  output logic          clr_q,
  output logic [AW-1:0] dst_snap_q,
  output logic [AW-1:0] src_snap_q
);
  localparam int NB = (AW + 7) / 8;
  localparam logic [7:0] OFS_DST_TOP = 8'(OFS_DST + NB - 1);

  logic req, go, host, busy_d, arm_d, pulse_d, clr_d;

  always_comb begin
    req = wr_en && (((wr_addr == OFS_CTL) && wr_data[CTL_GO_BIT]) ||
                    (rev_new && ctl_q[CTL_AUTO_BIT] && (wr_addr == OFS_DST_TOP)));
    go      = req && !busy_q;
    host    = (mode_q == HOST_SRC_MODE);
    pulse_d = go && !host;
    clr_d   = go && host;
    busy_d  = busy_q;
    arm_d   = arm_q;
    if (go) begin
      busy_d = 1'b1;
      arm_d  = host;
    end else if (eng_done) begin
      busy_d = 1'b0;
      arm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      arm_q      <= 1'b0;
      pulse_q    <= 1'b0;
      clr_q      <= 1'b0;
      dst_snap_q <= '0;
      src_snap_q <= '0;
    end else begin
      busy_q  <= busy_d;
      arm_q   <= arm_d;
      pulse_q <= pulse_d;
      clr_q   <= clr_d;
      if (clr_d) begin
        dst_snap_q <= dst_nxt;
        src_snap_q <= src_q;
      end
    end
  end
endmodule

// File: rtl/blt_ctl_top.sv
module blt_ctl_top
  import blt_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rev_new,
  input  logic          wide_addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          eng_done,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] src_addr,
  output logic [7:0]    mode,
  output logic [7:0]    mode_ext,
  output logic [7:0]    rop,
  output logic [15:0]   key_col,
  output logic [7:0]    ctl,
  output logic          busy,
  output logic          start_pulse,
  output logic          host_arm,
  output logic          cnt_clr,
  output logic [AW-1:0] dst_snap,
  output logic [AW-1:0] src_snap
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [AW-1:0] dst_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  blt_regfile #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .rev_new(rev_new), .wide_addr(wide_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dst_q(dst_addr), .dst_nxt(dst_nxt), .src_q(src_addr), .mode_q(mode),
    .mext_q(mode_ext), .rop_q(rop), .key_q(key_col), .ctl_q(ctl)
  );

  blt_launch #(.AW(AW)) u_launch (
    .clk(clk), .rst_n(rst_int_n), .rev_new(rev_new),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_q(ctl), .mode_q(mode), .dst_nxt(dst_nxt), .src_q(src_addr),
    .eng_done(eng_done), .busy_q(busy), .pulse_q(start_pulse),
    .arm_q(host_arm), .clr_q(cnt_clr), .dst_snap_q(dst_snap), .src_snap_q(src_snap)
  );
endmodule

// File: rtl/blt_ctl_chk.sv
module blt_ctl_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rev_new,
  input logic          wide_addr,
  input logic          wr_en,
  input logic [7:0]    wr_addr,
  input logic [AW-1:0] dst_addr,
  input logic [7:0]    mode_ext,
  input logic [15:0]   key_col,
  input logic          busy,
  input logic          start_pulse,
  input logic          host_arm,
  input logic          cnt_clr
);
  localparam int NB = (AW + 7) / 8;
  localparam logic [7:0] TOP_OFS = 8'(8'h10 + NB - 1);

  // R10
  pulse_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  // R10
  clr_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_clr);
  // R6
  pulse_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);
  // R9
  no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || cnt_clr) |-> !$past(busy));
  // R8
  host_launch_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> (host_arm && busy && !start_pulse));
  // R4
  mext_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rev_new) |-> $stable(mode_ext));
  // R5
  keylo_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rev_new) |-> $stable(key_col[7:0]));
  // R3
  narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(wr_addr) == TOP_OFS) && !$past(wide_addr)) |-> !dst_addr[AW-1]);
endmodule

bind blt_ctl_top blt_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rev_new(rev_new), .wide_addr(wide_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .dst_addr(dst_addr), .mode_ext(mode_ext),
  .key_col(key_col), .busy(busy), .start_pulse(start_pulse),
  .host_arm(host_arm), .cnt_clr(cnt_clr)
);

// File: tb/blt_ctl_top_tb.sv
`timescale 1ns/1ps
module blt_ctl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n, rev_new, wide_addr, wr_en, eng_done;
  logic [7:0]  wr_addr, wr_data;
  logic [21:0] dst_addr, src_addr, dst_snap, src_snap;
  logic [7:0]  mode, mode_ext, rop, ctl;
  logic [15:0] key_col;
  logic        busy, start_pulse, host_arm, cnt_clr;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  blt_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .rev_new(rev_new), .wide_addr(wide_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .eng_done(eng_done),
    .dst_addr(dst_addr), .src_addr(src_addr), .mode(mode), .mode_ext(mode_ext),
    .rop(rop), .key_col(key_col), .ctl(ctl), .busy(busy),
    .start_pulse(start_pulse), .host_arm(host_arm), .cnt_clr(cnt_clr),
    .dst_snap(dst_snap), .src_snap(src_snap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one write; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_blit();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 dst", {10'd0, dst_addr}, 0);
    check("R1 regs", {mode, mode_ext, rop, ctl}, 0);
    check("R1 key", {16'd0, key_col}, 0);
    check("R1 flags", {28'd0, busy, start_pulse, host_arm, cnt_clr}, 0);
    check("R1 snaps", {10'd0, dst_snap | src_snap}, 0);
  endtask

  task automatic t_fields();
    wide_addr = 1'b1;
    wr(8'h10, 8'h11); wr(8'h11, 8'h22); wr(8'h12, 8'hff);
    check("R3 wide dst", {10'd0, dst_addr}, 32'h3f2211);
    wide_addr = 1'b0;
    wr(8'h12, 8'hff);
    check("R3 narrow dst", {10'd0, dst_addr}, 32'h1f2211);
    wr(8'h14, 8'h44); wr(8'h15, 8'h55); wr(8'h16, 8'hff);
    check("R2 src", {10'd0, src_addr}, 32'h3f5544);
    wr(8'h18, 8'h01); wr(8'h1a, 8'hda);
    check("R2 mode rop", {16'd0, mode, rop}, 32'h01da);
    wr(8'h1d, 8'h12);
    check("R2 key high", {24'd0, key_col[15:8]}, 32'h12);
    check("R6 no launch from field writes", {30'd0, busy, start_pulse}, 0);
  endtask

  task automatic t_revision();
    rev_new = 1'b0;
    wr(8'h1b, 8'h5a);
    check("R4 ext ignored old rev", {24'd0, mode_ext}, 0);
    wr(8'h1c, 8'h77);
    check("R5 key low old rev", {16'd0, key_col}, 32'h1277);
    rev_new = 1'b1;
    wr(8'h1b, 8'h5a);
    check("R4 ext new rev", {24'd0, mode_ext}, 32'h5a);
    wr(8'h1c, 8'h88);
    check("R5 key low ignored new rev", {16'd0, key_col}, 32'h1277);
  endtask

  task automatic t_start();
    wr(8'h40, 8'h01);
    check("R6 no go bit", {30'd0, busy, start_pulse}, 0);
    wr(8'h40, 8'h02);
    check("R6 pulse and busy", {29'd0, busy, start_pulse, host_arm}, 32'b110);
    @(negedge clk);
    check("R10 pulse width", {30'd0, busy, start_pulse}, 32'b10);
    wr(8'h40, 8'h02);
    check("R9 ignored while busy", {30'd0, busy, start_pulse}, 32'b10);
    finish_blit();
    check("R9 done clears busy", {31'd0, busy}, 0);
  endtask

  task automatic t_auto();
    rev_new = 1'b1;
    wr(8'h40, 8'h80);
    check("R6 auto bit alone no launch", {31'd0, start_pulse}, 0);
    wr(8'h12, 8'h01);
    check("R7 auto launch", {30'd0, busy, start_pulse}, 32'b11);
    finish_blit();
    rev_new = 1'b0;
    wr(8'h12, 8'h02);
    check("R7 no auto old rev", {30'd0, busy, start_pulse}, 0);
    rev_new = 1'b1;
    wr(8'h40, 8'h00);
    wr(8'h12, 8'h03);
    check("R7 no auto bit clear", {30'd0, busy, start_pulse}, 0);
  endtask

  task automatic t_host();
    wide_addr = 1'b1;
    wr(8'h18, 8'h04);
    wr(8'h10, 8'h0a); wr(8'h11, 8'h0b); wr(8'h12, 8'h0c);
    wr(8'h14, 8'h01); wr(8'h15, 8'h02); wr(8'h16, 8'h03);
    wr(8'h40, 8'h02);
    check("R8 host launch flags", {28'd0, busy, start_pulse, host_arm, cnt_clr}, 32'b1011);
    check("R8 dst snapshot", {10'd0, dst_snap}, 32'h0c0b0a);
    check("R8 src snapshot", {10'd0, src_snap}, 32'h030201);
    @(negedge clk);
    check("R10 clr width", {30'd0, host_arm, cnt_clr}, 32'b10);
    finish_blit();
    check("R9 done clears arm", {30'd0, busy, host_arm}, 0);
    // auto-start in host mode latches the newly written top byte
    wr(8'h40, 8'h80);
    wr(8'h12, 8'h2d);
    check("R8 auto host snapshot", {10'd0, dst_snap}, 32'h2d0b0a);
    check("R8 auto host flags", {29'd0, start_pulse, host_arm, cnt_clr}, 32'b011);
    finish_blit();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rev_new = 1'b0; wide_addr = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fields();
    t_revision();
    t_start();
    t_auto();
    t_host();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule